// File: doc/BRIEF.md
# Two-Event Classification Indicator

This block decides whether a powered device was classified by a supply that ran two classification fingers with a mark interval between them. It does this before the device's converter starts. It does not see any analog voltage. It receives digital flags from comparators on the input supply. These flags cover the detection band, the classification window (about 12 V rising up to about 23 V), the mark level (below about 10 V) and the history-reset level (below about 4 V). It also receives the undervoltage-release flag, a flag saying the startup regulator is stable, and a flag saying a rear auxiliary source is present. It drives an active-low open-drain indication, modelled as a data output together with a pull-down enable.

Every incoming flag is asynchronous and passes through a synchronizer before it is used. A mark counts only after the mark flag has stayed high for `MARK_CYCLES` consecutive clocks. When undervoltage release occurs, the result is frozen from the classification history. The indication is then driven from that stored result whenever the startup regulator is stable and no auxiliary source is present. All pins are plain level signals and carry no stream traffic, so the block has no valid/ready handshake and no back-pressure.

Top module: `t2ev_indicator`

## Requirements
- R1: After reset the indication is released: `t2_pd_o` = 0 and `t2_n_o` = 1. While asserted, the outputs are `t2_pd_o` = 1 and `t2_n_o` = 0.
- R2: A rising edge of the classification-window flag counts as a classification event only if the detection flag has been seen since the last history clear.
- R3: A first event, then a mark, then a second event make up a two-event classification. If undervoltage release follows and the regulator is stable, the indication asserts.
- R4: If only one event occurred, or none, the indication stays released after power-up.
- R5: A second window entry with no mark since the first event is not counted.
- R6: A mark flag that is high for fewer than `MARK_CYCLES` consecutive synchronized clocks is not a mark. A mark flag high for exactly `MARK_CYCLES` clocks is a mark.
- R7: While the reset-level flag is high, detection status, the event count and the mark status are all cleared.
- R8: The indication is released while the regulator-stable flag is low.
- R9: While the auxiliary flag is high, the indication is released and the stored result is kept. When the flag is removed and the supply has not dropped out, the indication returns.
- R10: A fall of the undervoltage-release flag clears the stored result and the history. A later power-up with no new classification leaves the indication released.
- R11: The event count saturates at two. A third event, even one preceded by a mark, leaves the result asserted.
- R12: While the undervoltage-release flag is high, classification flags are ignored and the history is frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| det_band_i | input | 1 | Supply is in the detection band (asynchronous) |
| cls_win_i | input | 1 | Supply is in the classification window (asynchronous) |
| mark_lo_i | input | 1 | Supply is below the mark level (asynchronous) |
| hist_clr_i | input | 1 | Supply is below the history-reset level (asynchronous) |
| uv_ok_i | input | 1 | Undervoltage lockout released (asynchronous) |
| reg_ok_i | input | 1 | Startup regulator output is stable (asynchronous) |
| aux_i | input | 1 | Rear auxiliary source is present (asynchronous) |
| t2_n_o | output | 1 | Active-low indication level |
| t2_pd_o | output | 1 | Open-drain pull-down enable; 1 while the indication is asserted |

## Verification
An input change reaches the tracker state two clocks after the edge that samples it, because of the synchronizer. The indication register follows one clock after that, so the outputs settle three clocks after sampling. A mark needs another `MARK_CYCLES` clocks of level on top of this. The bench drives each stimulus on a falling edge and holds it for at least six clocks. It then waits eight more clocks before it samples the outputs, again on a falling edge, so every result is due well before it is checked. The mark-width boundary tests use pulses of exactly `MARK_CYCLES` and `MARK_CYCLES`-1 clocks. The synchronizer keeps the width of a pulse unchanged, so these lengths reach the filter intact.

// File: rtl/t2ev_pkg.sv
package t2ev_pkg;

  // Positions of the flags inside the synchronized flag vector
  localparam int FL_DET  = 0;
  localparam int FL_CLS  = 1;
  localparam int FL_MARK = 2;
  localparam int FL_CLR  = 3;
  localparam int FL_UV   = 4;
  localparam int FL_REG  = 5;
  localparam int FL_AUX  = 6;
  localparam int FLAG_W  = 7;

  // Saturating classification event count
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_ONE  = 2'd1,
    EV_TWO  = 2'd2
  } ev_cnt_t;

endpackage

// File: rtl/t2ev_sync.sv
module t2ev_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  generate
    genvar st;
    for (st = 0; st < STAGES; st++) begin : g_stage
      if (st == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[st] <= '0;
          else        pipe_q[st] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[st] <= '0;
          else        pipe_q[st] <= pipe_q[st-1];
        end
      end
    end
  endgenerate

  assign sync_o = pipe_q[STAGES-1];

endmodule

// File: rtl/t2ev_mark_filter.sv
module t2ev_mark_filter #(
  parameter int MARK_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mark_s_i,
  output logic mark_pulse_o
);

  localparam int CW = $clog2(MARK_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(MARK_CYCLES - 1);
  localparam logic [CW-1:0] CNT_SAT  = CW'(MARK_CYCLES);

  logic [CW-1:0] run_q;

  // Counts consecutive synchronized cycles with the mark flag high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run_q <= '0;
    else if (!mark_s_i)      run_q <= '0;
    else if (run_q != CNT_SAT) run_q <= run_q + 1'b1;
  end

  assign mark_pulse_o = mark_s_i && (run_q == CNT_LAST);

  // R6: a recognized mark needs the level on this and the previous cycle
  assert_mark_needs_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mark_pulse_o |-> (mark_s_i && $past(mark_s_i)));

endmodule

// File: rtl/t2ev_class_tracker.sv
module t2ev_class_tracker
  import t2ev_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic det_s_i,
  input  logic cls_s_i,
  input  logic mark_pulse_i,
  input  logic clr_s_i,
  input  logic uv_s_i,
  output logic powered_o,
  output logic result_o
);

  ev_cnt_t cnt_q;
  logic    armed_q, mark_seen_q, cls_q, uv_q;
  logic    cls_rise, uv_rise, uv_fall;

  assign cls_rise = cls_s_i && !cls_q;
  assign uv_rise  = uv_s_i && !uv_q;
  assign uv_fall  = uv_q && !uv_s_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= EV_NONE;
      armed_q     <= 1'b0;
      mark_seen_q <= 1'b0;
      cls_q       <= 1'b0;
      uv_q        <= 1'b0;
      powered_o   <= 1'b0;
      result_o    <= 1'b0;
    end else begin
      cls_q <= cls_s_i;
      uv_q  <= uv_s_i;
      if (uv_fall) begin
        powered_o   <= 1'b0;
        result_o    <= 1'b0;
        armed_q     <= 1'b0;
        cnt_q       <= EV_NONE;
        mark_seen_q <= 1'b0;
      end else begin
        if (uv_rise) begin
          powered_o <= 1'b1;
          result_o  <= (cnt_q == EV_TWO);
        end
        if (clr_s_i) begin
          armed_q     <= 1'b0;
          cnt_q       <= EV_NONE;
          mark_seen_q <= 1'b0;
        end else if (!uv_s_i) begin
          if (det_s_i) armed_q <= 1'b1;
          if (cls_rise && armed_q) begin
            case (cnt_q)
              EV_NONE: begin
                cnt_q       <= EV_ONE;
                mark_seen_q <= 1'b0;
              end
              EV_ONE: if (mark_seen_q) cnt_q <= EV_TWO;
              default: cnt_q <= cnt_q;
            endcase
          end else if (mark_pulse_i && cnt_q == EV_ONE) begin
            mark_seen_q <= 1'b1;
          end
        end
      end
    end
  end

  // R11: the count never leaves its three legal values
  assert_cnt_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q inside {EV_NONE, EV_ONE, EV_TWO});

  // R11: a saturated count holds unless cleared
  assert_cnt_saturates_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == EV_TWO && !clr_s_i && !uv_fall) |=> cnt_q == EV_TWO);

  // R2: nothing is counted before detection is seen
  assert_no_count_unarmed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && cnt_q == EV_NONE) |=> cnt_q == EV_NONE);

  // R10: a supply drop clears the stored result
  assert_drop_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    uv_fall |=> (!result_o && !powered_o));

  // R12: history frozen while powered
  assert_frozen_powered_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_s_i && uv_q && !clr_s_i) |=> $stable(cnt_q));

endmodule

// File: rtl/t2ev_indicator.sv
module t2ev_indicator
  import t2ev_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MARK_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic det_band_i,
  input  logic cls_win_i,
  input  logic mark_lo_i,
  input  logic hist_clr_i,
  input  logic uv_ok_i,
  input  logic reg_ok_i,
  input  logic aux_i,
  output logic t2_n_o,
  output logic t2_pd_o
);

  logic [FLAG_W-1:0] raw_flags, s_flags;
  logic mark_pulse, powered, result, ind_q;

  always_comb begin
    raw_flags          = '0;
    raw_flags[FL_DET]  = det_band_i;
    raw_flags[FL_CLS]  = cls_win_i;
    raw_flags[FL_MARK] = mark_lo_i;
    raw_flags[FL_CLR]  = hist_clr_i;
    raw_flags[FL_UV]   = uv_ok_i;
    raw_flags[FL_REG]  = reg_ok_i;
    raw_flags[FL_AUX]  = aux_i;
  end

  t2ev_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_flags),
    .sync_o  (s_flags)
  );

  t2ev_mark_filter #(.MARK_CYCLES(MARK_CYCLES)) u_mark (
    .clk          (clk),
    .rst_n        (rst_n),
    .mark_s_i     (s_flags[FL_MARK]),
    .mark_pulse_o (mark_pulse)
  );

  t2ev_class_tracker u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .det_s_i      (s_flags[FL_DET]),
    .cls_s_i      (s_flags[FL_CLS]),
    .mark_pulse_i (mark_pulse),
    .clr_s_i      (s_flags[FL_CLR]),
    .uv_s_i       (s_flags[FL_UV]),
    .powered_o    (powered),
    .result_o     (result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ind_q <= 1'b0;
    else        ind_q <= powered && result && s_flags[FL_REG] && !s_flags[FL_AUX];
  end

  assign t2_pd_o = ind_q;
  assign t2_n_o  = !ind_q;

  // R9: auxiliary presence releases the indication
  assert_aux_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    s_flags[FL_AUX] |=> !t2_pd_o);

  // R8: unstable regulator releases the indication
  assert_reg_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !s_flags[FL_REG] |=> !t2_pd_o);

  // R3: the indication only rises once power-up has latched a result
  assert_rise_needs_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(t2_pd_o) |-> $past(powered && result));

endmodule

// File: tb/t2ev_indicator_test.sv
module t2ev_indicator_test;

  localparam int MC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic det = 0, cls = 0, mark = 0, clr = 0, uv = 0, reg_ok = 0, aux = 0;
  logic t2_n, t2_pd;

  int checks = 0;
  int fails  = 0;

  // Bench model of the requirements
  bit m_armed, m_ms, m_pow, m_res;
  int m_cnt;

  always #10 clk = ~clk;

  t2ev_indicator #(.SYNC_STAGES(2), .MARK_CYCLES(MC)) uut (
    .clk(clk), .rst_n(rst_n), .det_band_i(det), .cls_win_i(cls),
    .mark_lo_i(mark), .hist_clr_i(clr), .uv_ok_i(uv), .reg_ok_i(reg_ok),
    .aux_i(aux), .t2_n_o(t2_n), .t2_pd_o(t2_pd)
  );

  function automatic bit exp_ind();
    return m_pow && m_res && reg_ok && !aux;
  endfunction

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req);
    bit e;
    wait_cyc(8);
    e = exp_ind();
    checks++;
    if (t2_pd !== e || t2_n !== !e) begin
      fails++;
      $display("FAIL %s: pd=%0b n=%0b expected pd=%0b n=%0b", req, t2_pd, t2_n, e, !e);
    end
  endtask

  task automatic op_detect();
    det = 1; wait_cyc(6); det = 0; wait_cyc(6);
    if (!uv && !clr) m_armed = 1;
  endtask

  task automatic op_finger();
    cls = 1; wait_cyc(6); cls = 0; wait_cyc(6);
    if (!uv && m_armed) begin
      if (m_cnt == 0) begin m_cnt = 1; m_ms = 0; end
      else if (m_cnt == 1 && m_ms) m_cnt = 2;
    end
  endtask

  task automatic op_mark(input int len);
    mark = 1; wait_cyc(len); mark = 0; wait_cyc(6);
    if (!uv && len >= MC && m_cnt == 1) m_ms = 1;
  endtask

  task automatic op_clear();
    clr = 1; wait_cyc(6); clr = 0; wait_cyc(6);
    m_armed = 0; m_cnt = 0; m_ms = 0;
  endtask

  task automatic op_up();
    uv = 1; wait_cyc(6);
    if (!m_pow) begin m_pow = 1; m_res = (m_cnt == 2); end
  endtask

  task automatic op_down();
    uv = 0; wait_cyc(6);
    if (m_pow) begin
      m_pow = 0; m_res = 0; m_armed = 0; m_cnt = 0; m_ms = 0;
    end
  endtask

  task automatic two_event();
    op_detect(); op_finger(); op_mark(MC + 3); op_finger();
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    wait_cyc(3);
    rst_n = 1;
    check("R1 reset state");

    // R3: full two-event sequence
    reg_ok = 1;
    two_event(); op_up(); check("R3 two-event asserts");
    // R9: aux hides and restores
    aux = 1; wait_cyc(2); check("R9 aux releases");
    aux = 0; wait_cyc(2); check("R9 aux removal restores");
    // R8: regulator gate
    reg_ok = 0; wait_cyc(2); check("R8 regulator unstable");
    reg_ok = 1; wait_cyc(2); check("R8 regulator stable");
    // R12: fingers while powered ignored
    op_finger(); check("R12 ignored while powered");
    // R10: drop clears; power-up again without classification
    op_down(); check("R10 drop releases");
    op_up(); check("R10 no result after drop");
    op_down();

    // R4: single event
    op_detect(); op_finger(); op_up(); check("R4 single event");
    op_down();
    // R4: no event
    op_up(); check("R4 no event"); op_down();
    // R2: no detection
    op_finger(); op_mark(MC + 3); op_finger(); op_up(); check("R2 unarmed fingers ignored");
    op_down();
    // R5: second entry without mark
    op_detect(); op_finger(); op_finger(); op_up(); check("R5 no mark between"); op_down();
    // R6: short mark, then exact-length mark
    op_detect(); op_finger(); op_mark(MC - 1); op_finger(); op_up(); check("R6 short mark rejected");
    op_down();
    op_detect(); op_finger(); op_mark(MC); op_finger(); op_up(); check("R6 exact mark accepted");
    op_down();
    // R7: clear wipes history
    two_event(); op_clear(); op_up(); check("R7 history cleared"); op_down();
    // R11: third event with mark keeps result
    two_event(); op_mark(MC + 3); op_finger(); op_up(); check("R11 third event saturates");
    op_down();

    // Constrained random mix
    for (int k = 0; k < 300; k++) begin
      int sel;
      sel = int'($urandom_range(0, 9));
      case (sel)
        0: op_detect();
        1, 2: op_finger();
        3: op_mark(int'($urandom_range(MC - 3, MC + 4)));
        4: op_clear();
        5: op_up();
        6: op_down();
        7: begin reg_ok = ~reg_ok; wait_cyc(2); end
        8: begin aux = ~aux; wait_cyc(2); end
        default: two_event();
      endcase
      check("R3/R9 random mix");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule